// File: doc/BRIEF.md
# Maintenance Linkage Word Loader

This block holds a 32-bit maintenance linkage word in a data register and hands its fields out to processor control state when microcode strobes ask for them. The word reaches the data register in one of two ways: a diagnose operation assembles it, or a main-storage read returns it. A 3-bit sequence counter, three supervisory status flags, an I/O-mode flag and a 12-bit microprogram address register are loaded from fixed fields of the word. Each group has its own strobe, so microcode can commit one group without touching the others.

After a diagnose supplies its word, a built-in two-step kernel issues the strobes by itself. The first step commits the sequence counter, the supervisory flags and the I/O-mode flag. The second step commits the microprogram address. A done pulse follows. External microcode strobes stay usable at all times and are combined with the kernel's strobes.

Bit numbering in this document counts from the most significant end: word bit 0 is `diag_word[31]` / `mem_word[31]`, and word bit n is port bit 31-n.

Top module: `mlw_loader`

## Requirements
- R1: While reset is applied, and for the two clock edges after `rst_n` rises, every output is 0.
- R2: At a clock edge where `diag_vld` is high and the kernel is idle, the data register takes `diag_word`. Otherwise, when `mem_vld` is high, it takes `mem_word`. When both are accepted in the same cycle, the diagnose word wins.
- R3: A cycle with `uo_scanctl` high and `uo_emit` equal to 4'b1000 loads `seq_ctr` from word bits 0-2 (port bits 31:29, bit 0 as MSB). It also loads `stor_en_flag` from bit 4 (port bit 27), `scan_flag` from bit 5 (port bit 26) and `sup_flag` from bit 6 (port bit 25). These outputs show the new values after that clock edge.
- R4: A cycle with `uo_scanctl` high and any other `uo_emit` value leaves `seq_ctr` and the three flags unchanged.
- R5: `uo_iomode` loads `io_mode` from word bit 7 (port bit 24).
- R6: `uo_addr_scan` loads `uaddr` from word bits 19-30 (port bits 12:1, bit 19 as MSB).
- R7: Word bits 3, 8-18 and 31 (port bits 28, 23:13 and 0) affect no output.
- R8: Strobes asserted in the same cycle each load only their own targets. A group whose strobe is low holds its value.
- R9: After a diagnose word is accepted at edge k, the kernel runs step 1 in the cycle that follows edge k. Step 1 acts as scan-control with the key emit plus the I/O-mode strobe. The kernel runs step 2 in the next cycle, which acts as the address strobe. `kern_done` is high for exactly the one cycle after step 2. `kern_busy` is high from step 1 through the done cycle.
- R10: A `diag_vld` while `kern_busy` is high is ignored. The kernel does not restart, and the diagnose word is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_vld | input | 1 | Diagnose word valid; starts the kernel when idle |
| diag_word | input | 32 | Word assembled by a diagnose |
| mem_vld | input | 1 | Storage-read word valid |
| mem_word | input | 32 | Word read from main storage |
| uo_scanctl | input | 1 | Scan-control micro-order |
| uo_emit | input | 4 | Emit constant with the micro-order |
| uo_iomode | input | 1 | I/O-mode micro-order |
| uo_addr_scan | input | 1 | Address scan micro-order |
| seq_ctr | output | 3 | Sequence counter |
| stor_en_flag | output | 1 | Supervisory storage-enable flag |
| scan_flag | output | 1 | Progressive-scan flag |
| sup_flag | output | 1 | Supervisory flag |
| io_mode | output | 1 | I/O-mode flag |
| uaddr | output | 12 | Microprogram address register |
| kern_busy | output | 1 | Kernel active (step 1, step 2, done) |
| kern_done | output | 1 | Kernel completion pulse |

## Verification
On every cycle the assertions check the following:
- each strobed group takes its field from the previous data register value, and an unstrobed group holds;
- a scan-control with a wrong emit changes nothing;
- the diagnose word wins the data register;
- the kernel steps in order, and its done pulse lasts one cycle.

Only the bench's scenarios can show the rest:
- that reserved bits never reach an output;
- that a diagnose during a running kernel is dropped;
- that the field bit orders are right, which needs chosen word patterns compared against an independent model.

// File: rtl/mlw_pkg.sv
package mlw_pkg;
  localparam int WORD_W     = 32;
  localparam int SEQ_W      = 3;
  localparam int ADDR_W     = 12;
  // Field positions in MSB-first word numbering (bit 0 = port bit WORD_W-1)
  localparam int SEQ_FIRST  = 0;
  localparam int SES_POS    = 4;
  localparam int PSC_POS    = 5;
  localparam int SUP_POS    = 6;
  localparam int IOM_POS    = 7;
  localparam int ADDR_FIRST = 19;
  // Converted to port bit indices
  localparam int SEQ_HI  = WORD_W - 1 - SEQ_FIRST;
  localparam int SES_IX  = WORD_W - 1 - SES_POS;
  localparam int PSC_IX  = WORD_W - 1 - PSC_POS;
  localparam int SUP_IX  = WORD_W - 1 - SUP_POS;
  localparam int IOM_IX  = WORD_W - 1 - IOM_POS;
  localparam int ADDR_HI = WORD_W - 1 - ADDR_FIRST;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_STEP1 = 2'd1,
    K_STEP2 = 2'd2,
    K_DONE  = 2'd3
  } kstate_t;

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic             ses;
    logic             psc;
    logic             sup;
  } ctl_t;
endpackage

// File: rtl/mlw_word_reg.sv
module mlw_word_reg
  import mlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kern_idle,
  input  logic              diag_vld,
  input  logic [WORD_W-1:0] diag_word,
  input  logic              mem_vld,
  input  logic [WORD_W-1:0] mem_word,
  output logic              diag_take,
  output logic [WORD_W-1:0] word_q
);
  logic              load_en;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    diag_take = diag_vld & kern_idle;
    load_en   = diag_take | mem_vld;
    word_d    = diag_take ? diag_word : mem_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (load_en) word_q <= word_d;
  end

  // R2: diagnose word has priority into the data register
  p_diag_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_vld && kern_idle) |=> (word_q == $past(diag_word)));
  p_mem_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld && !(diag_vld && kern_idle)) |=> (word_q == $past(mem_word)));
endmodule

// File: rtl/mlw_kernel.sv
module mlw_kernel
  import mlw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic k_scan,
  output logic k_iom,
  output logic k_addr,
  output logic busy,
  output logic done
);
  kstate_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      K_IDLE:  if (start) st_d = K_STEP1;
      K_STEP1: st_d = K_STEP2;
      K_STEP2: st_d = K_DONE;
      K_DONE:  st_d = K_IDLE;
      default: st_d = K_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= K_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    idle   = (st_q == K_IDLE);
    k_scan = (st_q == K_STEP1);
    k_iom  = (st_q == K_STEP1);
    k_addr = (st_q == K_STEP2);
    busy   = (st_q != K_IDLE);
    done   = (st_q == K_DONE);
  end

  // R9: step 1 is followed by step 2, which is followed by the done pulse
  p_step_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    k_scan |=> k_addr);
  p_done_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    k_addr |=> done);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: no restart while busy
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/mlw_ctl_regs.sv
module mlw_ctl_regs
  import mlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              scan_en,
  input  logic              iom_en,
  output ctl_t              ctl_q,
  output logic              iom_q
);
  ctl_t ctl_d;
  logic iom_d;

  always_comb begin
    ctl_d.seq = word[SEQ_HI -: SEQ_W];
    ctl_d.ses = word[SES_IX];
    ctl_d.psc = word[PSC_IX];
    ctl_d.sup = word[SUP_IX];
    iom_d     = word[IOM_IX];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (scan_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      iom_q <= 1'b0;
    else if (iom_en) iom_q <= iom_d;
  end

  // R3: sequence counter and flags follow the previous word on scan-control
  p_seq_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (ctl_q.seq == $past(word[SEQ_HI -: SEQ_W])));
  // R5
  p_iom_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iom_en |=> (iom_q == $past(word[IOM_IX])));
  // R8: no strobe, no change
  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(ctl_q));
  p_iom_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !iom_en |=> $stable(iom_q));
endmodule

// File: rtl/mlw_addr_reg.sv
module mlw_addr_reg
  import mlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              addr_en,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] addr_d;

  always_comb addr_d = word[ADDR_HI -: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R6
  p_addr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |=> (addr_q == $past(word[ADDR_HI -: ADDR_W])));
  // R8
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_en |=> $stable(addr_q));
endmodule

// File: rtl/mlw_loader.sv
module mlw_loader
  import mlw_pkg::*;
#(
  parameter int              EMIT_W      = 4,
  parameter logic [EMIT_W-1:0] EMIT_KEY  = 4'b1000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      diag_vld,
  input  logic [mlw_pkg::WORD_W-1:0] diag_word,
  input  logic                      mem_vld,
  input  logic [mlw_pkg::WORD_W-1:0] mem_word,
  input  logic                      uo_scanctl,
  input  logic [EMIT_W-1:0]         uo_emit,
  input  logic                      uo_iomode,
  input  logic                      uo_addr_scan,
  output logic [mlw_pkg::SEQ_W-1:0] seq_ctr,
  output logic                      stor_en_flag,
  output logic                      scan_flag,
  output logic                      sup_flag,
  output logic                      io_mode,
  output logic [mlw_pkg::ADDR_W-1:0] uaddr,
  output logic                      kern_busy,
  output logic                      kern_done
);
  // Reset: asserted asynchronously, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_i_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_i_n = sync_q[SYNC_STAGES-1];

  logic              kern_idle, diag_take;
  logic              k_scan, k_iom, k_addr;
  logic [WORD_W-1:0] word_q;
  logic              key_hit, scan_en, iom_en, addr_en;
  ctl_t              ctl_q;

  mlw_word_reg u_word (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .kern_idle (kern_idle),
    .diag_vld  (diag_vld),
    .diag_word (diag_word),
    .mem_vld   (mem_vld),
    .mem_word  (mem_word),
    .diag_take (diag_take),
    .word_q    (word_q)
  );

  mlw_kernel u_kern (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .start  (diag_take),
    .idle   (kern_idle),
    .k_scan (k_scan),
    .k_iom  (k_iom),
    .k_addr (k_addr),
    .busy   (kern_busy),
    .done   (kern_done)
  );

  always_comb begin
    key_hit = uo_scanctl & (uo_emit == EMIT_KEY);
    scan_en = key_hit | k_scan;
    iom_en  = uo_iomode | k_iom;
    addr_en = uo_addr_scan | k_addr;
  end

  mlw_ctl_regs u_ctl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .word    (word_q),
    .scan_en (scan_en),
    .iom_en  (iom_en),
    .ctl_q   (ctl_q),
    .iom_q   (io_mode)
  );

  mlw_addr_reg u_addr (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .word    (word_q),
    .addr_en (addr_en),
    .addr_q  (uaddr)
  );

  always_comb begin
    seq_ctr      = ctl_q.seq;
    stor_en_flag = ctl_q.ses;
    scan_flag    = ctl_q.psc;
    sup_flag     = ctl_q.sup;
  end

  // R4: wrong emit constant with no kernel step leaves the control group alone
  p_emit_gate_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (uo_scanctl && (uo_emit != EMIT_KEY) && !k_scan) |=>
      ($stable(seq_ctr) && $stable(stor_en_flag) && $stable(scan_flag) && $stable(sup_flag)));
  // R1: outputs are clear while internal reset is held
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_i_n |-> (seq_ctr == '0 && uaddr == '0 && !io_mode && !kern_busy && !kern_done));
endmodule

// File: tb/test_mlw_loader.sv
module test_mlw_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        diag_vld = 1'b0, mem_vld = 1'b0;
  logic [31:0] diag_word = '0, mem_word = '0;
  logic        uo_scanctl = 1'b0, uo_iomode = 1'b0, uo_addr_scan = 1'b0;
  logic [3:0]  uo_emit = '0;
  logic [2:0]  seq_ctr;
  logic        stor_en_flag, scan_flag, sup_flag, io_mode, kern_busy, kern_done;
  logic [11:0] uaddr;

  int n_tests = 0, n_fail = 0;
  localparam logic [3:0] KEY = 4'b1000;

  always #10 clk = ~clk;  // 50 MHz

  mlw_loader i_mlw_loader (
    .clk(clk), .rst_n(rst_n), .diag_vld(diag_vld), .diag_word(diag_word),
    .mem_vld(mem_vld), .mem_word(mem_word), .uo_scanctl(uo_scanctl),
    .uo_emit(uo_emit), .uo_iomode(uo_iomode), .uo_addr_scan(uo_addr_scan),
    .seq_ctr(seq_ctr), .stor_en_flag(stor_en_flag), .scan_flag(scan_flag),
    .sup_flag(sup_flag), .io_mode(io_mode), .uaddr(uaddr),
    .kern_busy(kern_busy), .kern_done(kern_done));

  // Behavioural reference model
  int          m_rel, m_kst;
  logic [31:0] m_word;
  logic [2:0]  m_seq;
  logic        m_ses, m_psc, m_sup, m_iom;
  logic [11:0] m_addr;

  function automatic logic wbit(logic [31:0] w, int n);  // MSB-first numbering
    return w[31-n];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_kst = 0; m_word = '0; m_seq = '0;
      m_ses = 0; m_psc = 0; m_sup = 0; m_iom = 0; m_addr = '0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit s1, s2, sc, io, ad, take;
      s1 = (m_kst == 1); s2 = (m_kst == 2);
      sc = (uo_scanctl && uo_emit == KEY) || s1;
      io = uo_iomode || s1;
      ad = uo_addr_scan || s2;
      take = diag_vld && (m_kst == 0);
      if (sc) begin
        m_seq = {wbit(m_word,0), wbit(m_word,1), wbit(m_word,2)};
        m_ses = wbit(m_word,4); m_psc = wbit(m_word,5); m_sup = wbit(m_word,6);
      end
      if (io) m_iom = wbit(m_word,7);
      if (ad) for (int i = 0; i < 12; i++) m_addr[11-i] = wbit(m_word, 19+i);
      if (take) m_word = diag_word;
      else if (mem_vld) m_word = mem_word;
      case (m_kst)
        0: m_kst = take ? 1 : 0;
        1: m_kst = 2;
        2: m_kst = 3;
        default: m_kst = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R3 seq_ctr", {29'd0, seq_ctr}, {29'd0, m_seq});
    chk("R3 flags", {29'd0, stor_en_flag, scan_flag, sup_flag}, {29'd0, m_ses, m_psc, m_sup});
    chk("R5 io_mode", {31'd0, io_mode}, {31'd0, m_iom});
    chk("R6 uaddr", {20'd0, uaddr}, {20'd0, m_addr});
    chk("R9 busy", {31'd0, kern_busy}, {31'd0, 1'(m_kst != 0)});
    chk("R9 done", {31'd0, kern_done}, {31'd0, 1'(m_kst == 3)});
  endtask

  // One clock: inputs already set; compare after the edge, then clear strobes
  task automatic step();
    @(posedge clk); @(negedge clk);
    cmp_all();
    diag_vld = 0; mem_vld = 0; uo_scanctl = 0; uo_iomode = 0;
    uo_addr_scan = 0; uo_emit = '0;
  endtask

  task automatic all_out_zero(string tag);
    chk(tag, {seq_ctr, stor_en_flag, scan_flag, sup_flag, io_mode, uaddr, kern_busy, kern_done},
        32'd0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    all_out_zero("R1 in reset");
    rst_n = 1;
    step(); all_out_zero("R1 after release edge 1");
    step(); all_out_zero("R1 after release edge 2");

    // R3: storage word then scan-control with key
    mem_word = 32'hA5C3_F00E; mem_vld = 1; step();
    uo_scanctl = 1; uo_emit = KEY; step();
    chk("R3 seq from bits 0-2", {29'd0, seq_ctr}, 32'd5);
    chk("R3 flags bits 4,5,6", {29'd0, stor_en_flag, scan_flag, sup_flag}, 32'b010);

    // R4: wrong emit values
    mem_word = 32'h5A3C_0000; mem_vld = 1; step();
    uo_scanctl = 1; uo_emit = 4'b0100; step();
    uo_scanctl = 1; uo_emit = 4'b1001; step();
    chk("R4 seq unchanged", {29'd0, seq_ctr}, 32'd5);

    // R5, R6 separately
    uo_iomode = 1; step();
    chk("R5 io_mode from bit 7", {31'd0, io_mode}, 32'd0);
    mem_word = 32'h0100_1FFE; mem_vld = 1; step();
    uo_iomode = 1; step();
    chk("R5 io_mode set", {31'd0, io_mode}, 32'd1);
    uo_addr_scan = 1; step();
    chk("R6 uaddr bits 19-30", {20'd0, uaddr}, 32'hFFF);

    // R8: all strobes together, then none
    mem_word = 32'hE400_0AAA; mem_vld = 1; step();
    uo_scanctl = 1; uo_emit = KEY; uo_iomode = 1; uo_addr_scan = 1; step();
    chk("R8 joint seq", {29'd0, seq_ctr}, 32'd7);
    chk("R8 joint addr", {20'd0, uaddr}, 32'h555);
    mem_word = 32'h0000_0000; mem_vld = 1; step();
    step(); step();
    chk("R8 hold addr", {20'd0, uaddr}, 32'h555);

    // R7: clear, then word with only ignored bits
    uo_scanctl = 1; uo_emit = KEY; uo_iomode = 1; uo_addr_scan = 1; step();
    mem_word = 32'h10FF_E001; mem_vld = 1; step();
    uo_scanctl = 1; uo_emit = KEY; uo_iomode = 1; uo_addr_scan = 1; step();
    all_out_zero("R7 ignored bits");

    // R9: diagnose kernel, with mem_vld in the same cycle (R2: diag wins)
    diag_word = 32'hD300_1234; diag_vld = 1; mem_word = 32'hFFFF_FFFF; mem_vld = 1; step();
    chk("R9 step1 busy", {31'd0, kern_busy}, 32'd1);
    step();
    chk("R2 diag wins seq", {29'd0, seq_ctr}, 32'd6);
    chk("R9 step1 io", {31'd0, io_mode}, 32'd1);
    // R10: diag during busy ignored
    diag_word = 32'h0000_0000; diag_vld = 1; step();
    chk("R9 step2 addr", {20'd0, uaddr}, 32'h91A);
    chk("R9 done pulse", {31'd0, kern_done}, 32'd1);
    step();
    chk("R9 done ends", {31'd0, kern_done | kern_busy}, 32'd0);
    uo_scanctl = 1; uo_emit = KEY; step();
    chk("R10 word not replaced", {29'd0, seq_ctr}, 32'd6);

    // Mixed random traffic against the model
    for (int i = 0; i < 400; i++) begin
      diag_vld = ($urandom % 5) == 0; diag_word = $urandom;
      mem_vld = ($urandom % 3) == 0;  mem_word = $urandom;
      uo_scanctl = $urandom % 2; uo_emit = ($urandom % 2) ? KEY : 4'($urandom);
      uo_iomode = $urandom % 2; uo_addr_scan = $urandom % 2;
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule